// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide unpacked form (a class code, a sign, an unbiased exponent, a normalised mantissa whose top bit is the integer one, and a sticky bit that stands for everything below the mantissa). It produces the 32-bit IEEE-754 single-precision encoding of that value. Rounding follows one of four selectable modes. The block detects results too large or too small for the format and reports inexact, underflow, overflow and operand-error conditions.

It sits at the end of an arithmetic datapath. The operation unit presents its unpacked result on the inputs. The packed word and the four flags appear on registered outputs one clock later. Every cycle is a new, independent conversion, and there is no handshake.

Top module: `sp_result_packer`

## Requirements
- R1: While rst_n is low, the packed word and all four flags are zero.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge. Bit 31 of the word always equals that sampled in_sign.
- R3: Class code 0 (zero) packs as a zero with the input sign, and no flag is raised.
- R4: Class code 2 (infinity) packs with exponent field 255 and fraction 0, and no flag is raised.
- R5: Class code 3 (NaN) packs with exponent field 255. The fraction is the 23 mantissa bits just below the integer bit, with fraction bit 22 (quiet) forced to one. No flag is raised.
- R6: Class code 1 (number) with biased exponent in_exp+127 in 1..254 packs with that exponent in bits 30:23 and the 23 bits below the integer bit, after rounding, in bits 22:0. Inexact is raised exactly when any discarded bit or the sticky bit is nonzero.
- R7: rnd_mode selects the rounding rule:
  - 0 rounds to nearest, ties to even.
  - 1 rounds toward zero.
  - 2 rounds toward plus infinity (up in magnitude only when positive and inexact).
  - 3 rounds toward minus infinity (up in magnitude only when negative and inexact).
- R8: When rounding carries the significand to 2.0, the exponent field is one higher and the fraction is zero.
- R9: A final biased exponent of 255 or more raises overflow, inexact and operand error. The result is infinity in mode 0, in mode 2 for positive values and in mode 3 for negative values. Otherwise it is the largest finite value: exponent 254, fraction all ones, input sign.
- R10: A number with biased exponent of 0 or below takes the subnormal path. The significand, integer bit included, is shifted right by one plus the deficit before rounding. The exponent field is 0, and underflow is raised for every such value whether or not it is exact.
- R11: A subnormal that rounds up into the integer position packs as the smallest normal (exponent 1, fraction 0) and still raises underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Significand, MSB is the integer one |
| in_sticky | input | 1 | OR of all bits below in_mant |
| rnd_mode | input | 2 | Rounding mode, see R7 |
| pk_word | output | 32 | Packed single-precision word |
| flg_inexact | output | 1 | Result was rounded or overflowed |
| flg_underflow | output | 1 | Subnormal path taken |
| flg_overflow | output | 1 | Exponent out of range |
| flg_operr | output | 1 | Raised together with overflow |

## Verification
Every result, the word and all four flags, is due exactly one rising edge after its inputs are sampled. The bench drives a vector on a falling edge and compares on the next falling edge, so each output has settled for half a period before it is read. For latency, the bench also reads the outputs once more just before that rising edge and requires the previous vector's word to still be present. The expected word and flags come from a bench model that walks the discarded bits one at a time rather than masking them.

// File: rtl/sp_result_packer.sv
module sp_result_packer #(
  parameter int MANT_W = 32,
  parameter int EXP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        rnd_mode,
  output logic [31:0]       pk_word,
  output logic              flg_inexact,
  output logic              flg_underflow,
  output logic              flg_overflow,
  output logic              flg_operr
);
  localparam int EXT_W = MANT_W + 1;
  localparam int DROP  = EXT_W - 24;
  localparam int SH_W  = $clog2(EXT_W + 1);
  localparam int BE_W  = EXP_W + 2;

  localparam logic [1:0] C_ZERO = 2'd0, C_NUM = 2'd1, C_INF = 2'd2, C_NAN = 2'd3;
  localparam logic [1:0] M_NEAR = 2'd0, M_ZERO = 2'd1, M_PINF = 2'd2, M_MINF = 2'd3;

  logic signed [BE_W-1:0] be_in, deficit, be_fin;
  logic                   sub;
  logic [SH_W-1:0]        sh;
  logic [EXT_W-1:0]       ext, shifted, drop_mask;
  logic                   lost, g, rest, inexact, up, toinf, ovf;
  logic [23:0]            keep;
  logic [24:0]            sum;
  logic [31:0]            word_d;
  logic [3:0]             flags_d;

  assign be_in   = $signed({{2{in_exp[EXP_W-1]}}, in_exp}) + BE_W'(127);
  assign sub     = (be_in <= 0);
  assign deficit = BE_W'(1) - be_in;
  assign sh      = !sub ? '0 :
                   (deficit >= BE_W'(EXT_W)) ? SH_W'(EXT_W) : SH_W'(deficit);

  assign ext       = {in_mant, in_sticky};
  assign shifted   = ext >> sh;
  assign drop_mask = ~({EXT_W{1'b1}} << sh);
  assign lost      = |(ext & drop_mask);

  assign keep    = shifted[EXT_W-1 -: 24];
  assign g       = shifted[DROP-1];
  assign rest    = (|shifted[DROP-2:0]) | lost;
  assign inexact = g | rest;

  always_comb begin
    case (rnd_mode)
      M_NEAR:  up = g & (rest | keep[0]);
      M_ZERO:  up = 1'b0;
      M_PINF:  up = inexact & ~in_sign;
      default: up = inexact & in_sign;
    endcase
  end

  assign sum    = {1'b0, keep} + 25'(up);
  assign be_fin = be_in + BE_W'(sum[24]);
  assign ovf    = !sub && (be_fin >= BE_W'(255));

  always_comb begin
    case (rnd_mode)
      M_NEAR:  toinf = 1'b1;
      M_ZERO:  toinf = 1'b0;
      M_PINF:  toinf = ~in_sign;
      default: toinf = in_sign;
    endcase
  end

  // flags_d = {operr, overflow, underflow, inexact}
  always_comb begin
    word_d  = {in_sign, 31'd0};
    flags_d = 4'd0;
    case (in_class)
      C_ZERO: ;
      C_INF:  word_d = {in_sign, 8'hFF, 23'd0};
      C_NAN:  word_d = {in_sign, 8'hFF, in_mant[MANT_W-2 -: 23] | 23'h400000};
      default: begin
        if (sub) begin
          word_d  = {in_sign, 7'd0, sum[23], sum[22:0]};
          flags_d = {2'b00, 1'b1, inexact};
        end else if (ovf) begin
          word_d  = toinf ? {in_sign, 8'hFF, 23'd0} : {in_sign, 8'hFE, 23'h7FFFFF};
          flags_d = 4'b1101;
        end else begin
          word_d  = {in_sign, be_fin[7:0], sum[22:0]};
          flags_d = {3'b000, inexact};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk_word <= '0;
      {flg_operr, flg_overflow, flg_underflow, flg_inexact} <= 4'd0;
    end else begin
      pk_word <= word_d;
      {flg_operr, flg_overflow, flg_underflow, flg_inexact} <= flags_d;
    end
  end

  // R2
  sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pk_word[31] == $past(in_sign));

  // R3
  zero_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_class) == C_ZERO) |->
      (pk_word[30:0] == 31'd0 && !flg_inexact && !flg_underflow && !flg_overflow && !flg_operr));

  // R5
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_class) == C_NAN) |-> (pk_word[30:23] == 8'hFF && pk_word[22]));

  // R9
  ovf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_overflow |-> (flg_inexact && flg_operr && !flg_underflow && pk_word[30:24] == 7'h7F));

  // R10
  sub_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_underflow |-> (pk_word[30:24] == 7'd0 && !flg_overflow));

  // R9
  operr_only_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_operr |-> flg_overflow);
endmodule

// File: tb/sp_result_packer_tb.sv
module sp_result_packer_tb;
  localparam int MANT_W = 32;
  localparam int EXP_W  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] in_class = 2'd0;
  logic in_sign = 1'b0;
  logic [EXP_W-1:0] in_exp = '0;
  logic [MANT_W-1:0] in_mant = '0;
  logic in_sticky = 1'b0;
  logic [1:0] rnd_mode = 2'd0;
  logic [31:0] pk_word;
  logic flg_inexact, flg_underflow, flg_overflow, flg_operr;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] prev_word = '0;

  always #2 clk = ~clk;

  sp_result_packer #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_class(in_class), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .rnd_mode(rnd_mode), .pk_word(pk_word), .flg_inexact(flg_inexact),
    .flg_underflow(flg_underflow), .flg_overflow(flg_overflow),
    .flg_operr(flg_operr));

  // returns {operr, overflow, underflow, inexact, word}
  function automatic logic [35:0] model(input logic [1:0] cls, input logic sg,
      input int ex, input logic [MANT_W-1:0] m, input logic stk, input logic [1:0] md);
    logic [63:0] v;
    int be, drop;
    logic half, below, up, unf, inx;
    logic [63:0] kp;
    if (cls == 2'd0) return {4'd0, sg, 31'd0};
    if (cls == 2'd2) return {4'd0, sg, 8'hFF, 23'd0};
    if (cls == 2'd3) return {4'd0, sg, 8'hFF, m[MANT_W-2 -: 23] | 23'h400000};
    v = {31'd0, m, stk};
    be = ex + 127;
    drop = MANT_W + 1 - 24;
    unf = 1'b0;
    if (be <= 0) begin
      drop = drop + 1 - be;
      unf = 1'b1;
    end
    half = 1'b0;
    below = 1'b0;
    kp = v;
    for (int i = 0; i < drop; i++) begin
      below = below | half;
      half = kp[0];
      kp = kp >> 1;
    end
    inx = half | below;
    case (md)
      2'd0: up = half && (below || kp[0]);
      2'd1: up = 1'b0;
      2'd2: up = inx && !sg;
      default: up = inx && sg;
    endcase
    kp = kp + 64'(up);
    if (unf) begin
      if (kp == 64'h800000) return {2'b00, 1'b1, inx, sg, 8'd1, 23'd0};
      return {2'b00, 1'b1, inx, sg, 8'd0, kp[22:0]};
    end
    if (kp == 64'h1000000) begin
      be = be + 1;
      kp = 64'd0;
    end
    if (be >= 255) begin
      if (md == 2'd0 || (md == 2'd2 && !sg) || (md == 2'd3 && sg))
        return {4'b1101, sg, 8'hFF, 23'd0};
      return {4'b1101, sg, 8'hFE, 23'h7FFFFF};
    end
    return {3'b000, inx, sg, 8'(be), kp[22:0]};
  endfunction

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got flags=%b word=%h expected flags=%b word=%h",
               tag, got[35:32], got[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  function automatic string tag_of(input logic [1:0] cls, input logic [35:0] e);
    if (cls == 2'd0) return "R3";
    if (cls == 2'd2) return "R4";
    if (cls == 2'd3) return "R5";
    if (e[34]) return "R9";
    if (e[33] && e[30:23] == 8'd1) return "R11";
    if (e[33]) return "R10";
    return "R6/R7/R8";
  endfunction

  task automatic apply(input logic [1:0] cls, input logic sg, input int ex,
      input logic [MANT_W-1:0] m, input logic stk, input logic [1:0] md, input string tag);
    logic [35:0] e;
    @(negedge clk);
    in_class = cls; in_sign = sg; in_exp = EXP_W'(ex); in_mant = m;
    in_sticky = stk; rnd_mode = md;
    e = model(cls, sg, ex, m, stk, md);
    #1;
    check("R2", {4'd0, pk_word}, {4'd0, prev_word});
    @(negedge clk);
    check(tag.len() != 0 ? tag : tag_of(cls, e),
          {flg_operr, flg_overflow, flg_underflow, flg_inexact, pk_word}, e);
    check("R2", {4'd0, 31'd0, pk_word[31]}, {4'd0, 31'd0, sg});
    prev_word = pk_word;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    in_class = 2'd3; in_mant = '1; in_exp = EXP_W'(300);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {flg_operr, flg_overflow, flg_underflow, flg_inexact, pk_word}, 36'd0);
    in_class = 2'd0; in_mant = '0; in_exp = '0;
    rst_n = 1'b1;
    @(negedge clk);
    prev_word = pk_word;

    apply(2'd1, 1'b0, 0, 32'h8000_0000, 1'b0, 2'd0, "R6");
    apply(2'd1, 1'b1, 0, 32'h8000_0000, 1'b0, 2'd0, "R6");
    apply(2'd0, 1'b1, 5, 32'h0, 1'b0, 2'd0, "R3");
    apply(2'd2, 1'b1, 0, 32'h0, 1'b0, 2'd1, "R4");
    apply(2'd3, 1'b0, 0, 32'h8000_0100, 1'b0, 2'd0, "R5");
    apply(2'd3, 1'b1, 0, 32'hE123_4500, 1'b0, 2'd0, "R5");
    // tie: guard set, nothing below, lsb 0 stays, lsb 1 rounds
    apply(2'd1, 1'b0, 3, 32'h8000_0080, 1'b0, 2'd0, "R7");
    apply(2'd1, 1'b0, 3, 32'h8000_0180, 1'b0, 2'd0, "R7");
    apply(2'd1, 1'b0, 3, 32'h8000_0080, 1'b1, 2'd0, "R7");
    apply(2'd1, 1'b0, 3, 32'h8000_0001, 1'b0, 2'd1, "R7");
    apply(2'd1, 1'b0, 3, 32'h8000_0001, 1'b0, 2'd2, "R7");
    apply(2'd1, 1'b1, 3, 32'h8000_0001, 1'b0, 2'd2, "R7");
    apply(2'd1, 1'b1, 3, 32'h8000_0001, 1'b0, 2'd3, "R7");
    apply(2'd1, 1'b0, 10, 32'hFFFF_FF80, 1'b0, 2'd0, "R8");
    for (int md = 0; md < 4; md++) begin
      apply(2'd1, 1'b0, 127, 32'hFFFF_FFFF, 1'b0, 2'(md), "R9");
      apply(2'd1, 1'b1, 127, 32'hFFFF_FFFF, 1'b0, 2'(md), "R9");
      apply(2'd1, 1'b1, 400, 32'h8000_0000, 1'b0, 2'(md), "R9");
    end
    apply(2'd1, 1'b0, -127, 32'h8000_0000, 1'b0, 2'd0, "R10");
    apply(2'd1, 1'b0, -149, 32'h8000_0000, 1'b0, 2'd1, "R10");
    apply(2'd1, 1'b0, -300, 32'h8000_0000, 1'b0, 2'd2, "R10");
    apply(2'd1, 1'b1, -300, 32'h8000_0000, 1'b0, 2'd0, "R10");
    apply(2'd1, 1'b0, -127, 32'hFFFF_FFFF, 1'b0, 2'd0, "R11");
    apply(2'd1, 1'b1, -127, 32'hFFFF_FF00, 1'b0, 2'd3, "R11");

    for (int k = 0; k < 4000; k++) begin
      logic [1:0] cls;
      int r;
      r = int'($urandom_range(0, 15));
      cls = (r < 12) ? 2'd1 : 2'(r - 12);
      apply(cls, 1'($urandom), int'($urandom_range(0, 330)) - 180,
            {1'b1, 31'($urandom)}, 1'($urandom), 2'($urandom), "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule